// File: doc/BRIEF.md
# Prioritized Message Interrupt Controller

This block receives interrupt messages from a bus response channel and delivers them, one at a time, to a single processing core. Each message names a target core number, a 3-bit urgency level, an 8-bit cause code, a 16-bit requester identifier (bus/device/function of the sender) and a 2-bit security state. The identifier and the security state travel with the interrupt, so the core can pick a vector table that matches the sender's context. Messages for other cores are discarded. Accepted messages wait in one small FIFO for each urgency level.

The core takes interrupts through a valid/ready handshake. Normally the most urgent non-empty level is served first. Service is never handed to one level forever: after a run of consecutive grants from higher levels while a lower level waits, one grant goes to the lower level that has waited longest.

Two sticky indications report misuse. Each level has an overflow bit that records a message dropped at a full FIFO. A stuck-source flag records a requester that keeps raising the same cause without the core acknowledging anything. The flag comes with the identifier and cause of that requester.

Top module: `msg_irq_ctrl`

## Requirements
- R1: A message is accepted only when `msg_valid` is high and `msg_core` equals the `CORE_ID` parameter. Any other message changes no output and no stored state.
- R2: An accepted message is queued in the FIFO chosen by its `msg_prio` value (8 FIFOs, 4 entries each), and each FIFO is served in arrival order. When the output is empty, a message accepted at clock edge N shows on `irq_valid` after edge N+1.
- R3: At each load of the output, the highest non-empty level is chosen (7 is most urgent, 0 least), unless R7 applies. `irq_prio` reports the level of the presented interrupt.
- R4: `irq_cause`, `irq_rid` and `irq_sec` equal the `msg_cause`, `msg_rid` and `msg_sec` of the delivered message, bit for bit.
- R5: A message that reaches a full FIFO is dropped, and bit L of `ovf_flags` (L = its level) is set. That bit stays set until reset.
- R6: While `irq_valid` is high and `irq_ready` is low, the output stays valid and its fields do not change. A new interrupt is loaded only when the output is empty or a handshake (valid and ready high together) takes place.
- R7: A starvation counter adds one for each normal grant made while some level below the chosen one is non-empty. It clears on any other grant. When the counter is at 16 and a lower level is non-empty, the next load serves a lower level, and the counter clears.
- R8: Each level has an age, counted in loads. At each load, a non-empty level that is not chosen ages by one (saturating at 31), and every other level goes to 0. An inverted grant takes the oldest level below the most urgent non-empty one. On equal ages it takes the higher level.
- R9: When the same requester identifier and cause arrive in 8 consecutive accepted messages without a handshake in between, `stuck_flag` sets and stays set until reset. `stuck_rid` and `stuck_cause` latch that first offender and then hold.
- R10: A handshake restarts the repeat count. A message accepted in the same cycle as a handshake counts as the first of a new run.
- R11: After reset, `irq_valid`, `ovf_flags` and `stuck_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | A message is present on the response channel |
| msg_core | input | 4 | Target core number of the message |
| msg_prio | input | 3 | Urgency level of the message |
| msg_cause | input | 8 | Cause code |
| msg_rid | input | 16 | Requester bus/device/function identifier |
| msg_sec | input | 2 | Security state code |
| irq_valid | output | 1 | An interrupt is offered to the core |
| irq_ready | input | 1 | The core takes the offered interrupt |
| irq_prio | output | 3 | Level of the offered interrupt |
| irq_cause | output | 8 | Cause code of the offered interrupt |
| irq_rid | output | 16 | Requester identifier of the offered interrupt |
| irq_sec | output | 2 | Security state of the offered interrupt |
| ovf_flags | output | 8 | Sticky per-level drop indication, bit index = level |
| stuck_flag | output | 1 | Sticky stuck-source indication |
| stuck_rid | output | 16 | Identifier of the first stuck requester |
| stuck_cause | output | 8 | Cause of the first stuck requester |

## Verification
On every cycle, the assertions check that a held interrupt stays frozen until the core accepts it, that overflow bits and the stuck flag never clear once set, and that a message for another core never touches the overflow bits. They also check that the stuck flag rises only right after an accepted message. Other behaviour can be shown only by the bench scenarios, which compare every cycle against a reference model: the order of service across every pair of levels, the exact grant at which starvation relief occurs and which lower level it picks, the drop point of each FIFO, and the repeat count that marks a source stuck, including a restart by a handshake.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;
   localparam int CAUSE_W = 8;
   localparam int RID_W   = 16;
   localparam int SEC_W   = 2;

   typedef struct packed {
      logic [RID_W-1:0]   rid;
      logic [CAUSE_W-1:0] cause;
      logic [SEC_W-1:0]   sec;
   } irq_payload_t;
endpackage

// File: rtl/irq_lvl_fifo.sv
module irq_lvl_fifo
   import msg_irq_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  irq_payload_t din,
   output irq_payload_t head,
   output logic         full,
   output logic         empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("irq_lvl_fifo: DEPTH must be at least 1");
   end

   irq_payload_t     mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [CNT_W-1:0] cnt;
   logic             do_push, do_pop;

   if (DEPTH == 1) begin : g_single
      assign rd_nxt = '0;
      assign wr_nxt = '0;
   end else if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign rd_nxt = rd_ptr + 1'b1;
      assign wr_nxt = wr_ptr + 1'b1;
   end else begin : g_wrap
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
   end

   assign full    = (cnt == CNT_W'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int NLVL       = 8,
   parameter int STARVE_LIM = 16,
   parameter int AGE_W      = 5,
   localparam int LVL_W     = $clog2(NLVL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NLVL-1:0]  ne,
   input  logic             grant,
   output logic [LVL_W-1:0] lvl
);
   localparam int SC_W = $clog2(STARVE_LIM + 2);
   localparam logic [AGE_W-1:0] AGE_MAX = '1;

   if (NLVL < 2) begin : g_bad_nlvl
      $error("irq_pick: NLVL must be at least 2");
   end

   logic [AGE_W-1:0] age [NLVL];
   logic [SC_W-1:0]  scnt;
   logic [LVL_W-1:0] top, old;
   logic             lower_any, found, use_inv;
   logic [AGE_W-1:0] best;

   always_comb begin
      top = '0;
      for (int l = 0; l < NLVL; l++)
         if (ne[l]) top = LVL_W'(l);
      lower_any = 1'b0;
      found     = 1'b0;
      best      = '0;
      old       = '0;
      for (int l = 0; l < NLVL; l++) begin
         if (ne[l] && (l < int'(top))) begin
            lower_any = 1'b1;
            if (!found || age[l] >= best) begin
               found = 1'b1;
               best  = age[l];
               old   = LVL_W'(l);
            end
         end
      end
   end

   if (STARVE_LIM > 0) begin : g_inv
      assign use_inv = lower_any && (scnt == SC_W'(STARVE_LIM));
   end else begin : g_no_inv
      assign use_inv = 1'b0;
   end

   assign lvl = use_inv ? old : top;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scnt <= '0;
         for (int l = 0; l < NLVL; l++) age[l] <= '0;
      end else if (grant) begin
         if (use_inv)        scnt <= '0;
         else if (lower_any) scnt <= scnt + 1'b1;
         else                scnt <= '0;
         for (int l = 0; l < NLVL; l++)
            age[l] <= (ne[l] && (LVL_W'(l) != lvl)) ?
                      ((age[l] == AGE_MAX) ? age[l] : age[l] + 1'b1) : '0;
      end
   end
endmodule

// File: rtl/irq_stuck_det.sv
module irq_stuck_det
   import msg_irq_pkg::*;
#(
   parameter int STUCK_LIM = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arrive,
   input  logic [RID_W-1:0]   rid,
   input  logic [CAUSE_W-1:0] cause,
   input  logic               ack,
   output logic               flag,
   output logic [RID_W-1:0]   frid,
   output logic [CAUSE_W-1:0] fcause
);
   localparam int CW = $clog2(STUCK_LIM + 1);

   if (STUCK_LIM < 2) begin : g_bad_lim
      $error("irq_stuck_det: STUCK_LIM must be at least 2");
   end

   logic [CW-1:0]      cnt, cnt_nxt;
   logic [RID_W-1:0]   last_rid;
   logic [CAUSE_W-1:0] last_cause;
   logic               same;

   assign same = (rid == last_rid) && (cause == last_cause);

   always_comb begin
      cnt_nxt = ack ? '0 : cnt;
      if (arrive) begin
         if (!ack && same)
            cnt_nxt = (cnt == CW'(STUCK_LIM)) ? cnt : cnt + 1'b1;
         else
            cnt_nxt = CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt        <= '0;
         last_rid   <= '0;
         last_cause <= '0;
         flag       <= 1'b0;
         frid       <= '0;
         fcause     <= '0;
      end else begin
         cnt <= cnt_nxt;
         if (arrive) begin
            last_rid   <= rid;
            last_cause <= cause;
         end
         if (arrive && (cnt_nxt == CW'(STUCK_LIM)) && !flag) begin
            flag   <= 1'b1;
            frid   <= rid;
            fcause <= cause;
         end
      end
   end
endmodule

// File: rtl/msg_irq_ctrl.sv
module msg_irq_ctrl
   import msg_irq_pkg::*;
#(
   parameter int          PRIO_W     = 3,
   parameter int          DEPTH      = 4,
   parameter int          CORE_W     = 4,
   parameter int          CORE_ID    = 0,
   parameter int          STARVE_LIM = 16,
   parameter int          STUCK_LIM  = 8,
   parameter int          AGE_W      = 5,
   localparam int         NLVL       = 1 << PRIO_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               msg_valid,
   input  logic [CORE_W-1:0]  msg_core,
   input  logic [PRIO_W-1:0]  msg_prio,
   input  logic [CAUSE_W-1:0] msg_cause,
   input  logic [RID_W-1:0]   msg_rid,
   input  logic [SEC_W-1:0]   msg_sec,
   output logic               irq_valid,
   input  logic               irq_ready,
   output logic [PRIO_W-1:0]  irq_prio,
   output logic [CAUSE_W-1:0] irq_cause,
   output logic [RID_W-1:0]   irq_rid,
   output logic [SEC_W-1:0]   irq_sec,
   output logic [NLVL-1:0]    ovf_flags,
   output logic               stuck_flag,
   output logic [RID_W-1:0]   stuck_rid,
   output logic [CAUSE_W-1:0] stuck_cause
);
   if (CORE_ID >= (1 << CORE_W)) begin : g_bad_core
      $error("msg_irq_ctrl: CORE_ID does not fit in CORE_W bits");
   end

   irq_payload_t      in_pl, out_pl;
   irq_payload_t      heads [NLVL];
   logic [NLVL-1:0]   full, empty, push, pop;
   logic [PRIO_W-1:0] sel_lvl, out_lvl;
   logic              accept, hs, load, out_v;

   assign in_pl  = '{rid: msg_rid, cause: msg_cause, sec: msg_sec};
   assign accept = msg_valid && (msg_core == CORE_W'(CORE_ID));
   assign hs     = out_v && irq_ready;
   assign load   = (!out_v || hs) && !(&empty);

   for (genvar g = 0; g < NLVL; g++) begin : g_lvl
      assign push[g] = accept && (msg_prio == PRIO_W'(g));
      assign pop[g]  = load && (sel_lvl == PRIO_W'(g));

      irq_lvl_fifo #(.DEPTH(DEPTH)) u_fifo (
         .clk(clk), .rst_n(rst_n), .push(push[g]), .pop(pop[g]),
         .din(in_pl), .head(heads[g]), .full(full[g]), .empty(empty[g])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)                ovf_flags[g] <= 1'b0;
         else if (push[g] && full[g]) ovf_flags[g] <= 1'b1;
      end
   end

   irq_pick #(.NLVL(NLVL), .STARVE_LIM(STARVE_LIM), .AGE_W(AGE_W)) u_pick (
      .clk(clk), .rst_n(rst_n), .ne(~empty), .grant(load), .lvl(sel_lvl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_v   <= 1'b0;
         out_lvl <= '0;
         out_pl  <= '0;
      end else if (load) begin
         out_v   <= 1'b1;
         out_lvl <= sel_lvl;
         out_pl  <= heads[sel_lvl];
      end else if (hs) begin
         out_v   <= 1'b0;
      end
   end

   irq_stuck_det #(.STUCK_LIM(STUCK_LIM)) u_stuck (
      .clk(clk), .rst_n(rst_n), .arrive(accept), .rid(msg_rid),
      .cause(msg_cause), .ack(hs), .flag(stuck_flag), .frid(stuck_rid),
      .fcause(stuck_cause)
   );

   assign irq_valid = out_v;
   assign irq_prio  = out_lvl;
   assign irq_cause = out_pl.cause;
   assign irq_rid   = out_pl.rid;
   assign irq_sec   = out_pl.sec;
endmodule

// File: rtl/msg_irq_ctrl_chk.sv
module msg_irq_ctrl_chk
   import msg_irq_pkg::*;
#(
   parameter int PRIO_W  = 3,
   parameter int CORE_W  = 4,
   parameter int CORE_ID = 0,
   parameter int NLVL    = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               msg_valid,
   input logic [CORE_W-1:0]  msg_core,
   input logic               irq_valid,
   input logic               irq_ready,
   input logic [PRIO_W-1:0]  irq_prio,
   input logic [CAUSE_W-1:0] irq_cause,
   input logic [RID_W-1:0]   irq_rid,
   input logic [SEC_W-1:0]   irq_sec,
   input logic [NLVL-1:0]    ovf_flags,
   input logic               stuck_flag,
   input logic [RID_W-1:0]   stuck_rid,
   input logic [CAUSE_W-1:0] stuck_cause
);
   logic mine;
   assign mine = msg_valid && (msg_core == CORE_W'(CORE_ID));

   assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_prio) &&
         $stable(irq_cause) && $stable(irq_rid) && $stable(irq_sec)));

   assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

   assert_foreign_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !mine |=> $stable(ovf_flags));

   assert_stuck_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stuck_flag |=> (stuck_flag && $stable(stuck_rid) && $stable(stuck_cause)));

   assert_stuck_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stuck_flag) |-> $past(mine));
endmodule

bind msg_irq_ctrl msg_irq_ctrl_chk #(
   .PRIO_W(PRIO_W), .CORE_W(CORE_W), .CORE_ID(CORE_ID), .NLVL(NLVL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_core(msg_core),
   .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_prio(irq_prio),
   .irq_cause(irq_cause), .irq_rid(irq_rid), .irq_sec(irq_sec),
   .ovf_flags(ovf_flags), .stuck_flag(stuck_flag), .stuck_rid(stuck_rid),
   .stuck_cause(stuck_cause)
);

// File: tb/msg_irq_ctrl_bench.sv
module msg_irq_ctrl_bench;
   import msg_irq_pkg::*;

   localparam int MYCORE = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_v = 1'b0;
   logic [3:0]  in_core = '0;
   logic [2:0]  in_prio = '0;
   logic [7:0]  in_cause = '0;
   logic [15:0] in_rid = '0;
   logic [1:0]  in_sec = '0;
   logic        rdy = 1'b0;

   logic        irq_valid, stuck_flag;
   logic [2:0]  irq_prio;
   logic [7:0]  irq_cause, stuck_cause, ovf_flags;
   logic [15:0] irq_rid, stuck_rid;
   logic [1:0]  irq_sec;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   msg_irq_ctrl #(.CORE_ID(MYCORE)) u_msg_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .msg_valid(in_v), .msg_core(in_core),
      .msg_prio(in_prio), .msg_cause(in_cause), .msg_rid(in_rid),
      .msg_sec(in_sec), .irq_valid(irq_valid), .irq_ready(rdy),
      .irq_prio(irq_prio), .irq_cause(irq_cause), .irq_rid(irq_rid),
      .irq_sec(irq_sec), .ovf_flags(ovf_flags), .stuck_flag(stuck_flag),
      .stuck_rid(stuck_rid), .stuck_cause(stuck_cause)
   );

   // reference model, built from the requirements
   irq_payload_t mq [8][4];
   int           mn [8];
   int           mage [8];
   int           mscnt;
   bit           mov;
   int           mol;
   irq_payload_t mopl;
   bit [7:0]     movf;
   int           kcnt;
   logic [15:0]  krid;
   logic [7:0]   kcause;
   bit           mstk;
   logic [15:0]  mstk_rid;
   logic [7:0]   mstk_cause;

   task automatic model_reset();
      for (int l = 0; l < 8; l++) begin mn[l] = 0; mage[l] = 0; end
      mscnt = 0; mov = 0; mol = 0; mopl = '0; movf = '0;
      kcnt = 0; krid = '0; kcause = '0; mstk = 0; mstk_rid = '0; mstk_cause = '0;
   endtask

   task automatic model_step();
      bit hs, ld, lower_any, inv, found, acc, push_ok, ne [8];
      int top, pick, best, nc;
      irq_payload_t pl;
      hs = mov && rdy;
      top = -1;
      for (int l = 0; l < 8; l++) begin
         ne[l] = (mn[l] > 0);
         if (ne[l]) top = l;
      end
      ld = (!mov || hs) && (top >= 0);
      lower_any = 0; found = 0; best = 0; pick = top;
      for (int l = 0; l < top; l++)
         if (ne[l]) begin
            lower_any = 1;
            if (!found || mage[l] >= best) begin found = 1; best = mage[l]; pick = l; end
         end
      inv = lower_any && (mscnt == 16);
      if (!inv) pick = top;
      acc = in_v && (in_core == 4'(MYCORE));
      push_ok = acc && (mn[in_prio] < 4);
      pl = '{rid: in_rid, cause: in_cause, sec: in_sec};
      if (ld) begin
         mov = 1; mol = pick; mopl = mq[pick][0];
         for (int i = 0; i < 3; i++) mq[pick][i] = mq[pick][i+1];
         mn[pick]--;
         for (int l = 0; l < 8; l++)
            mage[l] = (ne[l] && l != pick) ? ((mage[l] == 31) ? 31 : mage[l] + 1) : 0;
         mscnt = inv ? 0 : (lower_any ? mscnt + 1 : 0);
      end else if (hs) mov = 0;
      if (push_ok) begin mq[in_prio][mn[in_prio]] = pl; mn[in_prio]++; end
      if (acc && !push_ok) movf[in_prio] = 1;
      nc = hs ? 0 : kcnt;
      if (acc) begin
         if (!hs && in_rid == krid && in_cause == kcause) nc = (kcnt == 8) ? 8 : kcnt + 1;
         else nc = 1;
         krid = in_rid; kcause = in_cause;
         if (nc == 8 && !mstk) begin mstk = 1; mstk_rid = in_rid; mstk_cause = in_cause; end
      end
      kcnt = nc;
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R6 valid", 32'(irq_valid), 32'(mov));
      if (mov) begin
         chk("R3 prio", 32'(irq_prio), 32'(mol));
         chk("R4 cause", 32'(irq_cause), 32'(mopl.cause));
         chk("R4 rid", 32'(irq_rid), 32'(mopl.rid));
         chk("R4 sec", 32'(irq_sec), 32'(mopl.sec));
      end
      chk("R5 ovf", 32'(ovf_flags), 32'(movf));
      chk("R9 stuck", 32'(stuck_flag), 32'(mstk));
      if (mstk) begin
         chk("R9 rid", 32'(stuck_rid), 32'(mstk_rid));
         chk("R9 cause", 32'(stuck_cause), 32'(mstk_cause));
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      if (rst_n) model_step(); else model_reset();
      @(negedge clk);
      if (rst_n) compare_all();
   endtask

   task automatic do_reset();
      rst_n = 0; in_v = 0; rdy = 0;
      cyc(); cyc();
      rst_n = 1;
      chk("R11 valid", 32'(irq_valid), 0);
      chk("R11 ovf", 32'(ovf_flags), 0);
      chk("R11 stuck", 32'(stuck_flag), 0);
   endtask

   task automatic send(int core, int prio, int rid, int cause, int sec);
      in_v = 1; in_core = 4'(core); in_prio = 3'(prio);
      in_rid = 16'(rid); in_cause = 8'(cause); in_sec = 2'(sec);
      cyc();
      in_v = 0;
   endtask

   task automatic idle(int n, bit r);
      rdy = r;
      for (int i = 0; i < n; i++) cyc();
      rdy = 0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      int hsn;
      model_reset();
      do_reset();

      // R2: latency of one message into an empty output
      send(MYCORE, 4, 16'h0101, 8'h11, 1);
      chk("R2 not yet", 32'(irq_valid), 0);
      cyc();
      chk("R2 visible", 32'(irq_valid), 1);
      idle(2, 1);

      // R1: foreign cores ignored
      for (int c = 0; c < 16; c++)
         if (c != MYCORE) send(c, c % 8, 16'h0F00 + c, c, c % 4);
      idle(3, 0);
      chk("R1 nothing offered", 32'(irq_valid), 0);

      // R2/R3/R4: every pair of levels
      for (int a = 0; a < 8; a++)
         for (int b = 0; b < 8; b++) begin
            send(MYCORE, a, 16'h2000 + a * 16 + b, a * 8 + b, a % 4);
            send(MYCORE, b, 16'h3000 + a * 16 + b, b * 8 + a, b % 4);
            send(MYCORE, 8 - 1, 16'h3000 + b, 0, 0);
            send(MYCORE == 0 ? 1 : 0, 7, 16'hDEAD, 1, 1);
            idle(5, 1);
         end

      // R5: overflow on each level
      do_reset();
      for (int l = 0; l < 8; l++) begin
         for (int k = 0; k < 6; k++) send(MYCORE, l, 16'h4000 + l * 8 + k, k, 2);
         chk("R5 level bit", 32'(ovf_flags[l]), 1);
         idle(7, 1);
      end

      // R10 then R9
      do_reset();
      for (int k = 0; k < 7; k++) send(MYCORE, 3, 16'h1234, 8'h5A, 0);
      idle(1, 1);
      for (int k = 0; k < 7; k++) send(MYCORE, 3, 16'h1234, 8'h5A, 0);
      chk("R10 not stuck", 32'(stuck_flag), 0);
      send(MYCORE, 3, 16'h1234, 8'h5A, 0);
      chk("R9 stuck set", 32'(stuck_flag), 1);
      chk("R9 rid latched", 32'(stuck_rid), 32'h1234);
      send(MYCORE, 2, 16'h7777, 8'h01, 0);
      chk("R9 holds first", 32'(stuck_cause), 32'h5A);
      idle(10, 1);

      // R6: long hold with changing inputs
      do_reset();
      send(MYCORE, 1, 16'h0A0A, 8'h33, 3);
      for (int k = 0; k < 6; k++) send(MYCORE, 6, 16'h0B00 + k, k, 1);
      chk("R6 held", 32'(irq_rid), 32'h0A0A);
      idle(10, 1);

      // R7/R8: starvation relief
      do_reset();
      send(MYCORE, 0, 16'h5000, 8'hA0, 0);
      cyc();
      send(MYCORE, 0, 16'h5001, 8'hB0, 0);
      send(MYCORE, 1, 16'h5002, 8'hC0, 0);
      for (int k = 0; k < 4; k++) send(MYCORE, 7, 16'h6000 + k, k, 1);
      hsn = 0;
      for (int it = 0; it < 40; it++) begin
         hsn++;
         if (hsn == 18) chk("R7 inverted to level", 32'(irq_prio), 1);
         if (hsn >= 2 && hsn <= 17) chk("R3 urgent run", 32'(irq_prio), 7);
         if (hsn == 35) chk("R8 oldest remaining", 32'(irq_prio), 0);
         idle(1, 1);
         send(MYCORE, 7, 16'h6100 + it, 8'h80 + it, 1);
      end
      idle(12, 1);

      summary();
      $finish;
   end
endmodule